// File: doc/BRIEF.md
# Dual-Address Synchronous Pass-Through RAM

This block is a single-clock memory with two fully independent access ports, X and Y. Each port has its own address, write data, read data, active-low write strobe, a pair of select inputs (one active low, one active high), an active-low pass-through request and an asynchronous active-low output enable. On any cycle each port may read the array, write it, sit idle (deselected), or forward its own write data to the opposite port's read output without touching the array. Both ports work in the same cycle, and same-location conflicts are settled by fixed rules, so that the result never depends on timing.

All inputs except the output enables are captured in an input register stage on the rising clock edge. On the following rising edge the captured operation executes: the array is written and each port's output register loads either forwarded data or the array word. A word requested at edge N is therefore on the read-data output after edge N+1. The output register keeps its value until the next read or forward into that port. Bidirectional pads are represented by a read-data output plus a drive-enable output. The address width is a parameter: the default keeps the simulation array small, and an address width of 17 with a 36-bit word gives the full 131,072-word geometry.

Top module: `dual_addr_pt_ram`

## Requirements
- R1: Inputs sampled at rising edge N are executed at edge N+1, and a read or forward requested at edge N is visible on the read-data output after edge N+1.
- R2: A port is selected only when its active-low select is sampled 0 and its active-high select is sampled 1. A deselected port does not write, does not read and sends no forward, and its read-data output holds.
- R3: A selected port with the write strobe sampled 0 stores its write data at its address.
- R4: A selected port with the write strobe sampled 1 and its own pass-through request sampled 1 loads the stored word at its address into its output register. Writes and idle cycles leave the output register unchanged.
- R5: When both ports are selected and X's pass-through request is sampled 0, Y's output register loads X's write data, and this takes priority over a read by Y.
- R6: When both ports are selected and Y's pass-through request is sampled 0, X's output register loads Y's write data. Both forwards may happen in the same cycle, and either may come with a write by its source port.
- R7: When both ports read the same address in one cycle, both get the stored word.
- R8: When one port reads an address that the other port writes in the same cycle, the reader gets the word held before the write, and later reads return the new word.
- R9: When both ports write the same address in one cycle, only Y's data is stored.
- R10: A port's drive enable is 1 exactly when its output enable is 0, with no clock involved. It is 0 throughout reset and until the first rising edge after reset is released. The output registers read 0 after reset.
- R11: A port whose own pass-through request is sampled 0 with its write strobe at 1 does not read the array. Its output changes only if the other port forwards to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| x_addr | input | ADDR_W | Port X address |
| x_wdata | input | WIDTH | Port X write / forward data |
| x_we_n | input | 1 | Port X write strobe, active low |
| x_en_n | input | 1 | Port X select, active low |
| x_en | input | 1 | Port X select, active high |
| x_thru_n | input | 1 | Port X forward-to-Y request, active low |
| x_oe_n | input | 1 | Port X output enable, asynchronous, active low |
| x_rdata | output | WIDTH | Port X read data |
| x_drive | output | 1 | Port X pad drive enable |
| y_addr | input | ADDR_W | Port Y address |
| y_wdata | input | WIDTH | Port Y write / forward data |
| y_we_n | input | 1 | Port Y write strobe, active low |
| y_en_n | input | 1 | Port Y select, active low |
| y_en | input | 1 | Port Y select, active high |
| y_thru_n | input | 1 | Port Y forward-to-X request, active low |
| y_oe_n | input | 1 | Port Y output enable, asynchronous, active low |
| y_rdata | output | WIDTH | Port Y read data |
| y_drive | output | 1 | Port Y pad drive enable |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a forward into a port and that port's own read request. The second is a read and a write, or two writes, to the same address from both ports. The bench provokes the first by forwarding while the target port reads, writes or forwards back, and the second by sweeping every address through write/read, read/write, write/write and read/read pairs. A bench-side reference array and output model predicts each result two edges after the stimulus. Every output is judged against it: forwarded data must win over the read, a reader must see the pre-write word, and a double write must leave Y's value.

// File: rtl/dpt_pkg.sv
package dpt_pkg;
   localparam int NPORT = 2;
   localparam int PX    = 0;
   localparam int PY    = 1;

   function automatic logic port_selected(input logic en_n, input logic en);
      return (!en_n) && en;
   endfunction
endpackage

// File: rtl/dpt_port_front.sv
module dpt_port_front #(
   parameter int AW = 10,
   parameter int DW = 36
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] data_i,
   input  logic          we_n_i,
   input  logic          en_n_i,
   input  logic          en_i,
   input  logic          thru_n_i,
   output logic [AW-1:0] addr_q,
   output logic [DW-1:0] data_q,
   output logic          sel_q,
   output logic          we_n_q,
   output logic          thru_n_q
);
   import dpt_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q   <= '0;
         data_q   <= '0;
         sel_q    <= 1'b0;
         we_n_q   <= 1'b1;
         thru_n_q <= 1'b1;
      end else begin
         addr_q   <= addr_i;
         data_q   <= data_i;
         sel_q    <= port_selected(en_n_i, en_i);
         we_n_q   <= we_n_i;
         thru_n_q <= thru_n_i;
      end
   end
endmodule

// File: rtl/dpt_cycle_decode.sv
module dpt_cycle_decode #(
   parameter int AW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    sel,
   input  logic [1:0]    we_n,
   input  logic [1:0]    thru_n,
   input  logic [AW-1:0] addr_x,
   input  logic [AW-1:0] addr_y,
   output logic [1:0]    wr,
   output logic [1:0]    rd,
   output logic [1:0]    pass_in
);
   import dpt_pkg::*;

   logic same_loc;
   logic both_sel;

   assign same_loc = (addr_x == addr_y);
   assign both_sel = sel[PX] & sel[PY];

   // Y keeps its write; X yields on a same-address double write
   assign wr[PY] = sel[PY] & ~we_n[PY];
   assign wr[PX] = sel[PX] & ~we_n[PX] & ~(wr[PY] & same_loc);

   // a port reads only with its own forward request idle
   assign rd[PX] = sel[PX] & we_n[PX] & thru_n[PX];
   assign rd[PY] = sel[PY] & we_n[PY] & thru_n[PY];

   // pass_in[p]: the opposite port forwards into port p
   assign pass_in[PY] = both_sel & ~thru_n[PX];
   assign pass_in[PX] = both_sel & ~thru_n[PY];

   // R2: nothing at all leaves a deselected port
   assert_deselect_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !sel[PX] |-> (!wr[PX] && !rd[PX] && !pass_in[PY]));
endmodule

// File: rtl/dpt_store.sv
module dpt_store #(
   parameter int AW = 10,
   parameter int DW = 36
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_x,
   input  logic          wr_y,
   input  logic [AW-1:0] addr_x,
   input  logic [AW-1:0] addr_y,
   input  logic [DW-1:0] data_x,
   input  logic [DW-1:0] data_y,
   output logic [DW-1:0] rdata_x,
   output logic [DW-1:0] rdata_y
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_x) cells[addr_x] <= data_x;
      if (wr_y) cells[addr_y] <= data_y;
   end

   // combinational read of the pre-edge contents: readers see old data
   assign rdata_x = cells[addr_x];
   assign rdata_y = cells[addr_y];

   // R3: an accepted X write is found in the array one edge later
   assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_x |=> cells[$past(addr_x)] == $past(data_x));

   // R9: a Y write always lands, even when X aimed at the same word
   assert_y_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_y |=> cells[$past(addr_y)] == $past(data_y));
endmodule

// File: rtl/dpt_out_stage.sv
module dpt_out_stage #(
   parameter int DW = 36
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_pass,
   input  logic [DW-1:0] pass_data,
   input  logic          ld_read,
   input  logic [DW-1:0] read_data,
   input  logic          oe_n,
   output logic [DW-1:0] dout,
   output logic          drive
);
   logic live;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live <= 1'b0;
      else        live <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       dout <= '0;
      else if (ld_pass) dout <= pass_data;
      else if (ld_read) dout <= read_data;
   end

   assign drive = live & ~oe_n;

   // R5 / R6: forwarded data wins over a read
   assert_pass_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ld_pass |=> dout == $past(pass_data));

   // R4: a plain read loads the array word
   assert_read_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_read && !ld_pass) |=> dout == $past(read_data));

   // R2 / R11: no load, no change
   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_read && !ld_pass) |=> $stable(dout));

   // R10: no drive at the first edge after reset release
   assert_drive_late_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> !drive);
endmodule

// File: rtl/dual_addr_pt_ram.sv
module dual_addr_pt_ram #(
   parameter int ADDR_W = 10,
   parameter int WIDTH  = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] x_addr,
   input  logic [WIDTH-1:0]  x_wdata,
   input  logic              x_we_n,
   input  logic              x_en_n,
   input  logic              x_en,
   input  logic              x_thru_n,
   input  logic              x_oe_n,
   output logic [WIDTH-1:0]  x_rdata,
   output logic              x_drive,
   input  logic [ADDR_W-1:0] y_addr,
   input  logic [WIDTH-1:0]  y_wdata,
   input  logic              y_we_n,
   input  logic              y_en_n,
   input  logic              y_en,
   input  logic              y_thru_n,
   input  logic              y_oe_n,
   output logic [WIDTH-1:0]  y_rdata,
   output logic              y_drive
);
   import dpt_pkg::*;

   if (ADDR_W < 1 || ADDR_W > 20) begin : g_bad_addr_w
      $error("dual_addr_pt_ram: ADDR_W must be 1..20");
   end
   if (WIDTH < 1 || WIDTH > 256) begin : g_bad_width
      $error("dual_addr_pt_ram: WIDTH must be 1..256");
   end

   // pins gathered per port
   logic [ADDR_W-1:0] pin_addr [NPORT];
   logic [WIDTH-1:0]  pin_data [NPORT];
   logic [1:0]        pin_we_n, pin_en_n, pin_en, pin_thru_n, pin_oe_n;

   assign pin_addr[PX] = x_addr;
   assign pin_addr[PY] = y_addr;
   assign pin_data[PX] = x_wdata;
   assign pin_data[PY] = y_wdata;
   assign pin_we_n     = {y_we_n,   x_we_n};
   assign pin_en_n     = {y_en_n,   x_en_n};
   assign pin_en       = {y_en,     x_en};
   assign pin_thru_n   = {y_thru_n, x_thru_n};
   assign pin_oe_n     = {y_oe_n,   x_oe_n};

   // captured operation
   logic [ADDR_W-1:0] q_addr [NPORT];
   logic [WIDTH-1:0]  q_data [NPORT];
   logic [1:0]        q_sel, q_we_n, q_thru_n;

   logic [1:0]        op_wr, op_rd, op_pass_in;
   logic [WIDTH-1:0]  arr_rd [NPORT];
   logic [WIDTH-1:0]  out_q  [NPORT];
   logic [1:0]        out_drv;

   for (genvar p = 0; p < NPORT; p++) begin : g_front
      dpt_port_front #(.AW(ADDR_W), .DW(WIDTH)) u_front (
         .clk      (clk),
         .rst_n    (rst_n),
         .addr_i   (pin_addr[p]),
         .data_i   (pin_data[p]),
         .we_n_i   (pin_we_n[p]),
         .en_n_i   (pin_en_n[p]),
         .en_i     (pin_en[p]),
         .thru_n_i (pin_thru_n[p]),
         .addr_q   (q_addr[p]),
         .data_q   (q_data[p]),
         .sel_q    (q_sel[p]),
         .we_n_q   (q_we_n[p]),
         .thru_n_q (q_thru_n[p])
      );
   end

   dpt_cycle_decode #(.AW(ADDR_W)) u_decode (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (q_sel),
      .we_n    (q_we_n),
      .thru_n  (q_thru_n),
      .addr_x  (q_addr[PX]),
      .addr_y  (q_addr[PY]),
      .wr      (op_wr),
      .rd      (op_rd),
      .pass_in (op_pass_in)
   );

   dpt_store #(.AW(ADDR_W), .DW(WIDTH)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_x    (op_wr[PX]),
      .wr_y    (op_wr[PY]),
      .addr_x  (q_addr[PX]),
      .addr_y  (q_addr[PY]),
      .data_x  (q_data[PX]),
      .data_y  (q_data[PY]),
      .rdata_x (arr_rd[PX]),
      .rdata_y (arr_rd[PY])
   );

   for (genvar p = 0; p < NPORT; p++) begin : g_out
      dpt_out_stage #(.DW(WIDTH)) u_out (
         .clk       (clk),
         .rst_n     (rst_n),
         .ld_pass   (op_pass_in[p]),
         .pass_data (q_data[NPORT-1-p]),
         .ld_read   (op_rd[p]),
         .read_data (arr_rd[p]),
         .oe_n      (pin_oe_n[p]),
         .dout      (out_q[p]),
         .drive     (out_drv[p])
      );
   end

   assign x_rdata = out_q[PX];
   assign y_rdata = out_q[PY];
   assign x_drive = out_drv[PX];
   assign y_drive = out_drv[PY];

   // R8: X reading the word Y writes returns the pre-write contents
   assert_read_old_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_rd[PX] && !op_pass_in[PX] && op_wr[PY] && q_addr[PX] == q_addr[PY])
      |=> x_rdata == $past(arr_rd[PX]));
endmodule

// File: tb/dual_addr_pt_ram_test.sv
module dual_addr_pt_ram_test;
   localparam int AW = 4;
   localparam int DW = 8;
   localparam int N  = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [AW-1:0] x_addr, y_addr;
   logic [DW-1:0] x_wdata, y_wdata, x_rdata, y_rdata;
   logic x_we_n, x_en_n, x_en, x_thru_n, x_oe_n, x_drive;
   logic y_we_n, y_en_n, y_en, y_thru_n, y_oe_n, y_drive;

   always #5 clk = ~clk;

   dual_addr_pt_ram #(.ADDR_W(AW), .WIDTH(DW)) uut (
      .clk(clk), .rst_n(rst_n),
      .x_addr(x_addr), .x_wdata(x_wdata), .x_we_n(x_we_n), .x_en_n(x_en_n),
      .x_en(x_en), .x_thru_n(x_thru_n), .x_oe_n(x_oe_n),
      .x_rdata(x_rdata), .x_drive(x_drive),
      .y_addr(y_addr), .y_wdata(y_wdata), .y_we_n(y_we_n), .y_en_n(y_en_n),
      .y_en(y_en), .y_thru_n(y_thru_n), .y_oe_n(y_oe_n),
      .y_rdata(y_rdata), .y_drive(y_drive)
   );

   typedef struct packed {
      logic xs_n, xs, xw_n, xt_n;
      logic [AW-1:0] xa;
      logic [DW-1:0] xd;
      logic ys_n, ys, yw_n, yt_n;
      logic [AW-1:0] ya;
      logic [DW-1:0] yd;
   } stim_t;

   int checks = 0;
   int fails  = 0;
   logic [DW-1:0] mref [N];
   logic [DW-1:0] exp_x = '0;
   logic [DW-1:0] exp_y = '0;
   stim_t p1, p2;
   string t1 = "idle";
   string t2 = "idle";

   function automatic stim_t mk(bit xsel, bit xwr, bit xpt, int xa, int xd,
                                bit ysel, bit ywr, bit ypt, int ya, int yd);
      stim_t r;
      r.xs_n = !xsel; r.xs = xsel; r.xw_n = !xwr; r.xt_n = !xpt;
      r.xa = AW'(xa); r.xd = DW'(xd);
      r.ys_n = !ysel; r.ys = ysel; r.yw_n = !ywr; r.yt_n = !ypt;
      r.ya = AW'(ya); r.yd = DW'(yd);
      return r;
   endfunction

   function automatic int pat(int a, int salt);
      return ((a * 37) ^ salt) & 255;
   endfunction

   task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic model(stim_t s);
      bit sx, sy, wx, wy, rx, ry, pxy, pyx;
      logic [DW-1:0] ox, oy;
      sx  = !s.xs_n && s.xs;
      sy  = !s.ys_n && s.ys;
      wx  = sx && !s.xw_n;
      wy  = sy && !s.yw_n;
      rx  = sx && s.xw_n && s.xt_n;
      ry  = sy && s.yw_n && s.yt_n;
      pxy = sx && sy && !s.xt_n;
      pyx = sx && sy && !s.yt_n;
      ox = pyx ? s.yd : (rx ? mref[s.xa] : exp_x);
      oy = pxy ? s.xd : (ry ? mref[s.ya] : exp_y);
      exp_x = ox;
      exp_y = oy;
      if (wx) mref[s.xa] = s.xd;
      if (wy) mref[s.ya] = s.yd;   // later store: Y wins a double write
   endtask

   task automatic apply(stim_t s);
      x_en_n = s.xs_n; x_en = s.xs; x_we_n = s.xw_n; x_thru_n = s.xt_n;
      x_addr = s.xa; x_wdata = s.xd;
      y_en_n = s.ys_n; y_en = s.ys; y_we_n = s.yw_n; y_thru_n = s.yt_n;
      y_addr = s.ya; y_wdata = s.yd;
   endtask

   // result of a stimulus applied at negedge k is checked at negedge k+2 (R1)
   task automatic step(stim_t s, string tag);
      @(negedge clk);
      model(p2);
      chk(t2, "x_rdata", x_rdata, exp_x);
      chk(t2, "y_rdata", y_rdata, exp_y);
      p2 = p1; t2 = t1;
      p1 = s;  t1 = tag;
      apply(s);
   endtask

   initial begin
      repeat (40000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
   end

   initial begin
      stim_t idle, s;
      idle = mk(0,0,0,0,0, 0,0,0,0,0);
      p1 = idle; p2 = idle;
      apply(idle);
      x_oe_n = 1'b0; y_oe_n = 1'b0;

      // R10: reset behaviour
      repeat (3) @(negedge clk);
      #1;
      chk("R10", "x_drive in reset", DW'(x_drive), '0);
      chk("R10", "y_drive in reset", DW'(y_drive), '0);
      chk("R10", "x_rdata reset", x_rdata, '0);
      chk("R10", "y_rdata reset", y_rdata, '0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R10", "x_drive before first edge", DW'(x_drive), '0);
      @(negedge clk);
      chk("R10", "x_drive after edge", DW'(x_drive), DW'(1));
      chk("R10", "y_drive after edge", DW'(y_drive), DW'(1));
      x_oe_n = 1'b1;
      #1;
      chk("R10", "x_drive oe high", DW'(x_drive), '0);
      chk("R10", "y_drive unaffected", DW'(y_drive), DW'(1));
      x_oe_n = 1'b0;
      #1;
      chk("R10", "x_drive oe low", DW'(x_drive), DW'(1));

      // R3: fill the array from both ports
      for (int a = 0; a < N/2; a++)
         step(mk(1,1,0,a,pat(a,8'h5A), 1,1,0,a+N/2,pat(a+N/2,8'h5A)), "R3");
      for (int a = 0; a < N; a++)
         step(mk(1,0,0,a,0, 1,0,0,N-1-a,0), "R3");

      // R4: reads interleaved with writes and idles that must not move outputs
      for (int a = 0; a < N; a++) begin
         step(mk(1,0,0,a,0, 1,1,0,(a+3)%N,pat(a,8'h33)), "R4");
         step(mk(1,1,0,(a+5)%N,pat(a,8'hC1), 0,0,0,0,0), "R4");
         step(idle, "R4");
      end

      // R2: every deselect encoding, with write and forward attempts
      for (int c = 0; c < 3; c++) begin
         for (int a = 0; a < N; a++) begin
            s = mk(1,1,1,a,pat(a,8'hE7), 1,0,0,a,0);
            s.xs_n = (c != 1); s.xs = (c == 0);
            step(s, "R2");
            s = mk(1,0,0,a,0, 1,1,1,a,pat(a,8'h99));
            s.ys_n = (c != 1); s.ys = (c == 0);
            step(s, "R2");
         end
         for (int a = 0; a < N; a++)
            step(mk(1,0,0,a,0, 1,0,0,a,0), "R2");
      end

      // R5, R6, R11: forwarding in each direction and both at once
      for (int a = 0; a < N; a++) begin
         step(mk(1,0,1,a,pat(a,8'h11), 1,0,0,a,0), "R5");
         step(mk(1,0,1,a,pat(a,8'h22), 1,1,0,(a+1)%N,pat(a,8'h44)), "R11");
         step(mk(1,1,0,a,pat(a,8'h66), 1,0,1,(a+7)%N,pat(a,8'h77)), "R6");
         step(mk(1,0,1,a,pat(a,8'h88), 1,0,1,a,pat(a,8'hAA)), "R6");
         step(mk(1,1,1,(a+2)%N,pat(a,8'hBB), 1,1,1,(a+2)%N,pat(a,8'hCC)), "R6");
         step(mk(1,0,0,(a+2)%N,0, 1,0,0,(a+2)%N,0), "R9");
      end

      // R7, R8, R9: same-address collisions of every read/write mix
      for (int a = 0; a < N; a++) begin
         step(mk(1,1,0,a,pat(a,8'h0F), 1,0,0,a,0), "R8");
         step(mk(1,0,0,a,0, 1,1,0,a,pat(a,8'hF0)), "R8");
         step(mk(1,1,0,a,pat(a,8'h3C), 1,1,0,a,pat(a,8'hC3)), "R9");
         step(mk(1,0,0,a,0, 1,0,0,a,0), "R9");
         step(mk(1,0,0,a,0, 1,0,0,a,0), "R7");
      end

      // R1: concurrent random traffic on both ports
      for (int i = 0; i < 600; i++) begin
         s = mk(1, $urandom%2 == 0, $urandom%4 == 0, $urandom%N, $urandom%256,
                1, $urandom%2 == 0, $urandom%4 == 0, $urandom%N, $urandom%256);
         if ($urandom%5 == 0) s.xs = 1'b0;
         if ($urandom%5 == 0) s.ys_n = 1'b1;
         if ($urandom%3 == 0) s.ya = s.xa;
         step(s, "R1");
      end

      step(idle, "R1");
      step(idle, "R1");
      step(idle, "R1");

      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
   end
endmodule